// File: doc/BRIEF.md
# Vectored Fast-Interrupt Priority Encoder

This block watches a bank of interrupt request lines and picks the one fast interrupt that should be served next. A source is a pending fast interrupt when its request line is high, its enable bit is set and its steering bit routes it to the fast class. Among the pending fast interrupts, the lowest-numbered one wins. A separate promotion register can lift chosen sources of the upper bank above every other source.

The winner is reported in a status word as its index plus one, placed two bits up. Software can add the word to the base of a jump table of 4-byte entries and branch there, and a value of zero means nothing is pending. Promotion changes which source is picked. It never changes the number reported for that source.

Software reaches the enable, steering and promotion registers, and reads the status word, through a simple single-cycle register port. The read data is registered.

Top module: `vic_fiq_encoder`

## Requirements
- R1: When a fast interrupt with index i wins, fiq_status bits 8:2 hold i+1, so the whole status word equals 4*(i+1).
- R2: fiq_status bits 1:0 and bits 31:9 always read zero, and after reset the whole status word is zero.
- R3: When no source is a pending fast interrupt, fiq_status reads zero.
- R4: Source i is a pending fast interrupt only if irq_req[i], its enable bit and its steering bit are all 1. Enable is at address 0 (sources 0-31, bit n is source n) and address 1 (sources 32-63, bit n is source 32+n). Steering is at address 2 (sources 0-31) and address 3 (sources 32-63), with a steering bit of 1 selecting the fast class.
- R5: Among pending fast interrupts of the same promotion class, the one with the lowest index wins.
- R6: The promotion register is at address 4. Bit k of it promotes source 32+k, and a pending promoted source wins over every pending source that is not promoted.
- R7: A promoted winner with index i still reports 4*(i+1).
- R8: The enable, steering and promotion registers reset to zero. A write with reg_we high stores reg_wdata, and reg_rdata shows the register at reg_addr after one rising edge.
- R9: A change on irq_req appears on fiq_status at the second rising edge after it is driven. A register write appears on fiq_status at the edge after the edge that stores it.
- R10: Address 5 reads the current status word. Writes to address 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 64 | Interrupt request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fiq_status | output | 32 | Registered vector offset of the winning fast interrupt |

## Verification
A wrong enable, steering or promotion bit, or a wrong request sample, shows at fiq_status as a wrong offset or a stray zero. This happens two edges after the request changes, or one edge after the register write. A broken priority chain shows up only when two or more sources are pending, so the sweep drives every pair of sources and then random sets with random promotion masks. A register fault also shows one edge later on reg_rdata.

// File: rtl/vic_fiq_pkg.sv
package vic_fiq_pkg;
  // Status word: encoded number shifted to form a 4-byte jump table offset
  localparam int unsigned OFFSET_SHIFT = 2;

  function automatic int unsigned code_width(input int unsigned n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/vic_fiq_regs.sv
module vic_fiq_regs #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [WORD_W-1:0]  status_word,
  output logic [NUM_SRC-1:0] en_vec,
  output logic [NUM_SRC-1:0] steer_vec,
  output logic [WORD_W-1:0]  errpri,
  output logic [WORD_W-1:0]  rdata
);
  localparam int unsigned NWORDS    = NUM_SRC / WORD_W;
  localparam int unsigned ERR_ADDR  = 2 * NWORDS;
  localparam int unsigned STAT_ADDR = 2 * NWORDS + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec    <= '0;
      steer_vec <= '0;
      errpri    <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (addr == ADDR_W'(w))          en_vec[w*WORD_W +: WORD_W]    <= wdata;
        if (addr == ADDR_W'(NWORDS + w)) steer_vec[w*WORD_W +: WORD_W] <= wdata;
      end
      if (addr == ADDR_W'(ERR_ADDR)) errpri <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      for (int w = 0; w < NWORDS; w++) begin
        if (addr == ADDR_W'(w))          rdata <= en_vec[w*WORD_W +: WORD_W];
        if (addr == ADDR_W'(NWORDS + w)) rdata <= steer_vec[w*WORD_W +: WORD_W];
      end
      if (addr == ADDR_W'(ERR_ADDR))  rdata <= errpri;
      if (addr == ADDR_W'(STAT_ADDR)) rdata <= status_word;
    end
  end
endmodule

// File: rtl/vic_fiq_qualify.sv
module vic_fiq_qualify #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic [NUM_SRC-1:0] steer_vec,
  input  logic [WORD_W-1:0]  errpri,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic [NUM_SRC-1:0] prom_vec
);
  localparam int unsigned PROMO_BASE = NUM_SRC - WORD_W;

  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] promo_mask;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= irq_req;
  end

  generate
    if (PROMO_BASE > 0) begin : g_split
      assign promo_mask = {errpri, {PROMO_BASE{1'b0}}};
    end else begin : g_full
      assign promo_mask = errpri[NUM_SRC-1:0];
    end
  endgenerate

  assign pend_vec = req_q & en_vec & steer_vec;
  assign prom_vec = pend_vec & promo_mask;
endmodule

// File: rtl/vic_fiq_pick.sv
module vic_fiq_pick #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_fiq_encode.sv
module vic_fiq_encode
  import vic_fiq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_vec,
  input  logic [NUM_SRC-1:0] prom_vec,
  output logic [WORD_W-1:0]  status_word
);
  localparam int unsigned CODE_W = code_width(NUM_SRC);
  localparam int unsigned IDX_W  = $clog2(NUM_SRC);
  localparam int unsigned TOP_W  = WORD_W - CODE_W - OFFSET_SHIFT;

  logic             pend_found, prom_found;
  logic [IDX_W-1:0] pend_idx, prom_idx, win_idx;
  logic [CODE_W-1:0] code;

  vic_fiq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_all (
    .vec(pend_vec), .found(pend_found), .idx(pend_idx)
  );

  vic_fiq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_prom (
    .vec(prom_vec), .found(prom_found), .idx(prom_idx)
  );

  always_comb begin
    win_idx = prom_found ? prom_idx : pend_idx;
    code    = pend_found ? (CODE_W'(win_idx) + CODE_W'(1)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_word <= '0;
    else     status_word <= {{TOP_W{1'b0}}, code, {OFFSET_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/vic_fiq_encoder.sv
module vic_fiq_encoder #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic [WORD_W-1:0]  fiq_status
);
  logic [NUM_SRC-1:0] en_vec, steer_vec, pend_vec, prom_vec;
  logic [WORD_W-1:0]  errpri;

  vic_fiq_regs #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status_word(fiq_status), .en_vec(en_vec), .steer_vec(steer_vec),
    .errpri(errpri), .rdata(reg_rdata)
  );

  vic_fiq_qualify #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_qual (
    .clk(clk), .rst(rst), .irq_req(irq_req), .en_vec(en_vec),
    .steer_vec(steer_vec), .errpri(errpri),
    .pend_vec(pend_vec), .prom_vec(prom_vec)
  );

  vic_fiq_encode #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_enc (
    .clk(clk), .rst(rst), .pend_vec(pend_vec), .prom_vec(prom_vec),
    .status_word(fiq_status)
  );
endmodule

// File: rtl/vic_fiq_checker.sv
module vic_fiq_checker
  import vic_fiq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] prom_vec,
  input logic [WORD_W-1:0]  errpri,
  input logic [WORD_W-1:0]  fiq_status
);
  localparam int unsigned CODE_W = code_width(NUM_SRC);

  logic [NUM_SRC-1:0] pend_d, prom_d, below_mask;
  logic [CODE_W-1:0]  code;
  logic [CODE_W-1:0]  win;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_d <= '0;
      prom_d <= '0;
    end else begin
      pend_d <= pend_vec;
      prom_d <= prom_vec;
    end
  end

  assign code       = fiq_status[CODE_W+OFFSET_SHIFT-1:OFFSET_SHIFT];
  assign win        = code - CODE_W'(1);
  assign below_mask = (NUM_SRC'(1) << win) - NUM_SRC'(1);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    fiq_status[OFFSET_SHIFT-1:0] == '0 && fiq_status[WORD_W-1:CODE_W+OFFSET_SHIFT] == '0); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> fiq_status == '0 && errpri == '0); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0) |=> fiq_status == '0); // R3

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
    (code != '0) |-> pend_d[win]); // R4

  AST_PROMO_WINS: assert property (@(posedge clk) disable iff (rst)
    (prom_d != '0) |-> (code != '0 && prom_d[win])); // R6

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && prom_d == '0) |-> (pend_d & below_mask) == '0); // R5
endmodule

bind vic_fiq_encoder vic_fiq_checker #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .pend_vec(pend_vec), .prom_vec(prom_vec),
  .errpri(errpri), .fiq_status(fiq_status)
);

// File: tb/vic_fiq_encoder_bench.sv
module vic_fiq_encoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_req = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, fiq_status;

  int checks = 0;
  int failures = 0;
  logic [63:0] m_en = '0, m_st = '0;
  logic [31:0] m_ep = '0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  vic_fiq_encoder u_vic_fiq_encoder (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fiq_status(fiq_status)
  );

  function automatic logic [31:0] model(logic [63:0] r, logic [63:0] en,
                                        logic [63:0] st, logic [31:0] ep);
    logic [63:0] p;
    p = r & en & st;
    for (int i = 32; i < 64; i++)
      if (p[i] && ep[i-32]) return 32'(i + 1) << 2;
    for (int i = 0; i < 64; i++)
      if (p[i]) return 32'(i + 1) << 2;
    return 32'd0;
  endfunction

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic setup(logic [63:0] en, logic [63:0] st, logic [31:0] ep);
    wr(0, en[31:0]); wr(1, en[63:32]); wr(2, st[31:0]); wr(3, st[63:32]); wr(4, ep);
    m_en = en; m_st = st; m_ep = ep;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic req_check(string tag, logic [63:0] r);
    @(negedge clk);
    irq_req = r;
    settle();
    chk(tag, fiq_status, model(r, m_en, m_st, m_ep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk("R2 reset status", fiq_status, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R8 reset reg", d, 32'd0);
    end
    // Nothing enabled: requests must be ignored
    req_check("R4 all req no enable", {64{1'b1}});
    chk("R3 idle zero", fiq_status, 32'd0);

    // Register readback
    setup(64'hA5A5_0F0F_1234_5678, 64'h0F0F_A5A5_8765_4321, 32'hDEAD_BEEF);
    rd(0, d); chk("R8 read en lo", d, 32'h1234_5678);
    rd(1, d); chk("R8 read en hi", d, 32'hA5A5_0F0F);
    rd(2, d); chk("R8 read steer lo", d, 32'h8765_4321);
    rd(3, d); chk("R8 read steer hi", d, 32'h0F0F_A5A5);
    rd(4, d); chk("R8 read errpri", d, 32'hDEAD_BEEF);

    // Single source sweep, all enabled and steered
    setup({64{1'b1}}, {64{1'b1}}, 32'd0);
    for (int i = 0; i < 64; i++) begin
      req_check("R1 single source", 64'd1 << i);
      chk("R1 offset value", fiq_status, 32'(i + 1) * 4);
      chk("R2 reserved bits", fiq_status & 32'hFFFF_FE03, 32'd0);
    end

    // All pairs, lowest wins
    for (int i = 0; i < 64; i++)
      for (int j = i + 1; j < 64; j++)
        req_check("R5 pair lowest", (64'd1 << i) | (64'd1 << j));

    // Qualification: steering or enable clear blocks a source
    setup({64{1'b1}}, 64'hFFFF_FFFF_FFFF_FFDF, 32'd0);
    req_check("R4 steer clear", 64'h20);
    chk("R4 steer clear zero", fiq_status, 32'd0);
    req_check("R4 steer clear next", 64'h60);
    setup(64'hFFFF_FFFF_FFFF_FFBF, {64{1'b1}}, 32'd0);
    req_check("R4 enable clear", 64'h40);
    chk("R4 enable clear zero", fiq_status, 32'd0);

    // Promotion: each upper source beats source 0
    for (int k = 0; k < 32; k++) begin
      setup({64{1'b1}}, {64{1'b1}}, 32'd1 << k);
      req_check("R6 promo over low", 64'd1 | (64'd1 << (32 + k)));
      chk("R7 promo number", fiq_status, 32'(33 + k) * 4);
    end
    // Promotion bit set but that source idle: normal order
    setup({64{1'b1}}, {64{1'b1}}, 32'h8000_0000);
    req_check("R6 promo idle", 64'h0000_0004_0000_0100);
    // Two promoted: lower index among promoted
    setup({64{1'b1}}, {64{1'b1}}, 32'h0001_0004);
    req_check("R5 two promoted", 64'h0001_0004_0000_0003);

    // R10: status readable, write ignored
    wr(5, 32'hFFFF_FFFF);
    settle();
    rd(5, d);
    chk("R10 status read", d, model(irq_req, m_en, m_st, m_ep));
    chk("R10 write ignored", fiq_status, model(irq_req, m_en, m_st, m_ep));

    // R9 latency of requests
    setup({64{1'b1}}, {64{1'b1}}, 32'd0);
    @(negedge clk); irq_req = 64'h8; settle();
    @(negedge clk); irq_req = 64'h2;
    @(negedge clk); chk("R9 req one edge", fiq_status, 32'd16);
    @(negedge clk); chk("R9 req two edges", fiq_status, 32'd8);
    // R9 latency of a register write
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'hFFFF_FFFD;
    @(negedge clk); reg_we = 1'b0;
    chk("R9 write same edge", fiq_status, 32'd8);
    @(negedge clk); chk("R9 write next edge", fiq_status, 32'd0);
    m_st[31:0] = 32'hFFFF_FFFD;

    // Random patterns
    for (int n = 0; n < 300; n++) begin
      logic [63:0] e, s, r;
      e = next_rand() | next_rand();
      s = next_rand() | next_rand();
      setup(e, s, 32'(next_rand()));
      r = next_rand() & next_rand();
      req_check("R6 random", r);
      req_check("R5 random sparse", r & next_rand() & next_rand());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule